// File: doc/BRIEF.md
# Status Select and Subcode Readout Port

This block drives the single serial data line that a host controller reads from. A read window is open while the host holds both the mode input and the load strobe high. In that window the line normally carries one internal status condition, picked by a three-bit selector from a configuration register. When the selector points at the subcode-ready flag, a rising edge of the host's serial clock switches the line into subcode mode. The buffered 96-bit Q-channel word is then copied into a private shift register and sent out most significant bit first, one bit for each further rising edge of the serial clock.

The host may stop after any number of bits, from 1 to 96, by pulling the strobe low. It may also leave the clock idle for as long as it likes, and the line holds its current bit. Because the word is captured when the read starts, a new frame arriving in the middle of a read does not disturb the bits already being sent. The block also holds the motor-speed comparators. They compare a measured speed count against a nominal count and raise two start flags and one stop flag. The stop threshold has a coarse and a fine setting. Host lines are sampled on the block clock, and status sources pass through one register stage before they reach the line.

Top module: `stsub_readout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, line_oe is 0 and line_out is 0.
- R2: line_oe is 1 only in the cycle after a clock edge at which host_mode and host_strobe were both 1. One cycle after either input is seen at 0, line_oe is 0 and line_out is 0.
- R3: In status mode, line_out is the source chosen by cfg_stat_sel, registered one clock: 0 = stat_subq_rdy_n (active low, passed as is), 1 = start1, 2 = start2, 3 = stop, 4 = stat_pll_lock, 5 = pin_v1, 6 = pin_v2, 7 = stat_motor_sat.
- R4: start1 is 1 exactly when 4·spd_meas ≥ 3·spd_nominal, and start2 is 1 exactly when 2·spd_meas ≥ spd_nominal.
- R5: stop is 1 exactly when 100·spd_meas ≤ 12·spd_nominal while cfg_stop_fine is 0, and exactly when 100·spd_meas ≤ 6·spd_nominal while cfg_stop_fine is 1.
- R6: Selectors 4 to 7 follow their input pins with a latency of one clock.
- R7: In status mode with selector 0, a rising edge of host_sclk captures subq_word and puts bit 95 on line_out from the next cycle.
- R8: Each later rising edge of host_sclk moves line_out to the next lower bit. While host_sclk does not rise, line_out holds, with no limit on time.
- R9: Changes on subq_word after the capture do not affect the bits sent in that read.
- R10: A read ends whenever the strobe falls, after any number of bits. A new read starts again at bit 95 of the word present at that time. Rising edges beyond the 96th bit make line_out 0.
- R11: A rising edge of host_sclk in status mode with a selector other than 0 does not start a subcode read. The line keeps following the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | Host mode select; reads are allowed only while high |
| host_strobe | input | 1 | Host load strobe; high opens a read, low ends it |
| host_sclk | input | 1 | Host serial clock; rising edges start and advance the subcode read |
| cfg_stat_sel | input | 3 | Status source selector field |
| cfg_stop_fine | input | 1 | Selects the 6% stop threshold instead of 12% |
| stat_subq_rdy_n | input | 1 | Subcode-ready flag, active low |
| stat_pll_lock | input | 1 | Sync coincidence lock flag |
| pin_v1 | input | 1 | External input V1 |
| pin_v2 | input | 1 | External input V2 |
| stat_motor_sat | input | 1 | Motor output stage saturation flag |
| spd_meas | input | 16 | Measured motor speed count |
| spd_nominal | input | 16 | Nominal motor speed count |
| subq_word | input | 96 | Buffered Q-channel subcode word |
| line_out | output | 1 | Serial data line value |
| line_oe | output | 1 | Serial data line output enable |

## Verification
A wrong phase shows at once on line_oe, or as status data where subcode bits belong, one cycle after the host edge that should have caused the change. A bit counter or shift register that has slipped shows as a wrong bit on the next sclk rise after the slip. A failure to capture the word shows up only when subq_word is changed during a read, so the bench does exactly that. Comparator errors appear only at the exact threshold counts, one cycle after the speed values are applied, so those counts and their neighbours are driven directly.

// File: rtl/stsub_pkg.sv
package stsub_pkg;

    localparam int STAT_SRC_N = 8;
    localparam int SEL_W      = $clog2(STAT_SRC_N);

    localparam int START1_NUM = 3;
    localparam int START1_DEN = 4;
    localparam int START2_NUM = 1;
    localparam int START2_DEN = 2;
    localparam int PCT_BASE   = 100;
    localparam int STOP_COARSE_PCT = 12;
    localparam int STOP_FINE_PCT   = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_SUBQ   = 3'd0,
        SEL_START1 = 3'd1,
        SEL_START2 = 3'd2,
        SEL_STOP   = 3'd3,
        SEL_PLL    = 3'd4,
        SEL_V1     = 3'd5,
        SEL_V2     = 3'd6,
        SEL_SAT    = 3'd7
    } stat_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STATUS = 2'd1,
        PH_SUBQ   = 2'd2
    } phase_e;

    typedef struct packed {
        logic subq_rdy_n;
        logic start1;
        logic start2;
        logic stop;
        logic pll;
        logic v1;
        logic v2;
        logic sat;
    } stat_flags_t;

    function automatic logic pick_flag(stat_flags_t f, stat_sel_e s);
        logic r;
        case (s)
            SEL_SUBQ:   r = f.subq_rdy_n;
            SEL_START1: r = f.start1;
            SEL_START2: r = f.start2;
            SEL_STOP:   r = f.stop;
            SEL_PLL:    r = f.pll;
            SEL_V1:     r = f.v1;
            SEL_V2:     r = f.v2;
            default:    r = f.sat;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stsub_speed_cmp.sv
module stsub_speed_cmp
    import stsub_pkg::*;
#(
    parameter int SPD_W = 16
) (
    input  logic [SPD_W-1:0] spd_meas,
    input  logic [SPD_W-1:0] spd_nominal,
    input  logic             stop_fine,
    output logic             start1,
    output logic             start2,
    output logic             stop
);
    // 7 extra bits cover a scale factor of up to 127
    localparam int PROD_W = SPD_W + 7;

    logic [PROD_W-1:0] meas_w, nom_w;
    logic [PROD_W-1:0] meas_x4, nom_x3, meas_x2, nom_x1;
    logic [PROD_W-1:0] meas_pct, nom_coarse, nom_fine;

    always_comb begin
        meas_w     = PROD_W'(spd_meas);
        nom_w      = PROD_W'(spd_nominal);
        meas_x4    = meas_w * PROD_W'(START1_DEN);
        nom_x3     = nom_w  * PROD_W'(START1_NUM);
        meas_x2    = meas_w * PROD_W'(START2_DEN);
        nom_x1     = nom_w  * PROD_W'(START2_NUM);
        meas_pct   = meas_w * PROD_W'(PCT_BASE);
        nom_coarse = nom_w  * PROD_W'(STOP_COARSE_PCT);
        nom_fine   = nom_w  * PROD_W'(STOP_FINE_PCT);
        start1 = (meas_x4 >= nom_x3);
        start2 = (meas_x2 >= nom_x1);
        stop   = stop_fine ? (meas_pct <= nom_fine) : (meas_pct <= nom_coarse);
    end

endmodule

// File: rtl/stsub_status_path.sv
module stsub_status_path
    import stsub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stat_flags_t flags_raw,
    input  stat_sel_e   sel,
    output stat_flags_t flags_q,
    output logic        stat_bit
);
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_raw;
    end

    assign stat_bit = pick_flag(flags_q, sel);

endmodule

// File: rtl/stsub_shift.sv
module stsub_shift #(
    parameter int WORD_W = 96,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] word,
    output logic              msb,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            sh_q    <= word;
            bit_cnt <= CNT_W'(1);
        end else if (adv) begin
            sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
            bit_cnt <= (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + CNT_W'(1);
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/stsub_ctrl.sv
module stsub_ctrl
    import stsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   host_mode,
    input  logic   host_strobe,
    input  logic   host_sclk,
    input  logic   sel_is_subq,
    output phase_e phase,
    output logic   load,
    output logic   adv
);
    logic   sclk_q;
    logic   sclk_rise;
    logic   active;
    phase_e phase_n;

    always_comb begin
        active    = host_mode && host_strobe;
        sclk_rise = host_sclk && !sclk_q;
        load      = active && sclk_rise && sel_is_subq && (phase == PH_STATUS);
        adv       = active && sclk_rise && (phase == PH_SUBQ);
        phase_n   = phase;
        if (!active) begin
            phase_n = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   phase_n = PH_STATUS;
                PH_STATUS: if (load) phase_n = PH_SUBQ;
                default:   phase_n = PH_SUBQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            sclk_q <= 1'b0;
        end else begin
            phase  <= phase_n;
            sclk_q <= host_sclk;
        end
    end

endmodule

// File: rtl/stsub_readout.sv
module stsub_readout
    import stsub_pkg::*;
#(
    parameter int SPD_W  = 16,
    parameter int WORD_W = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic              host_strobe,
    input  logic              host_sclk,
    input  logic [SEL_W-1:0]  cfg_stat_sel,
    input  logic              cfg_stop_fine,
    input  logic              stat_subq_rdy_n,
    input  logic              stat_pll_lock,
    input  logic              pin_v1,
    input  logic              pin_v2,
    input  logic              stat_motor_sat,
    input  logic [SPD_W-1:0]  spd_meas,
    input  logic [SPD_W-1:0]  spd_nominal,
    input  logic [WORD_W-1:0] subq_word,
    output logic              line_out,
    output logic              line_oe
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    stat_sel_e        sel;
    stat_flags_t      flags_raw;
    stat_flags_t      flags_q;
    phase_e           phase;
    logic             load, adv;
    logic             sh_msb, stat_bit;
    logic             cmp_start1, cmp_start2, cmp_stop;
    logic [CNT_W-1:0] bit_cnt;
    logic             in_subq;

    assign sel = stat_sel_e'(cfg_stat_sel);

    stsub_speed_cmp #(.SPD_W(SPD_W)) u_cmp (
        .spd_meas    (spd_meas),
        .spd_nominal (spd_nominal),
        .stop_fine   (cfg_stop_fine),
        .start1      (cmp_start1),
        .start2      (cmp_start2),
        .stop        (cmp_stop)
    );

    always_comb begin
        flags_raw.subq_rdy_n = stat_subq_rdy_n;
        flags_raw.start1     = cmp_start1;
        flags_raw.start2     = cmp_start2;
        flags_raw.stop       = cmp_stop;
        flags_raw.pll        = stat_pll_lock;
        flags_raw.v1         = pin_v1;
        flags_raw.v2         = pin_v2;
        flags_raw.sat        = stat_motor_sat;
    end

    stsub_status_path u_stat (
        .clk       (clk),
        .rst       (rst),
        .flags_raw (flags_raw),
        .sel       (sel),
        .flags_q   (flags_q),
        .stat_bit  (stat_bit)
    );

    stsub_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .host_mode   (host_mode),
        .host_strobe (host_strobe),
        .host_sclk   (host_sclk),
        .sel_is_subq (sel == SEL_SUBQ),
        .phase       (phase),
        .load        (load),
        .adv         (adv)
    );

    stsub_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .adv     (adv),
        .word    (subq_word),
        .msb     (sh_msb),
        .bit_cnt (bit_cnt)
    );

    assign in_subq = (phase == PH_SUBQ);
    assign line_oe = (phase != PH_IDLE);

    always_comb begin
        case (phase)
            PH_SUBQ:   line_out = sh_msb;
            PH_STATUS: line_out = stat_bit;
            default:   line_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/stsub_readout_chk.sv
module stsub_readout_chk #(
    parameter int WORD_W = 96,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_mode,
    input logic             host_strobe,
    input logic             host_sclk,
    input logic             line_out,
    input logic             line_oe,
    input logic             in_subq,
    input logic             flag_start1,
    input logic             flag_start2,
    input logic [CNT_W-1:0] bit_cnt
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= host_sclk;
    end

    p_tristate_mode_r2: assert property (@(posedge clk) disable iff (rst)
        !host_mode |=> !line_oe);

    p_tristate_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !host_strobe |=> (!line_oe && !line_out));

    p_oe_needs_host_r2: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> $past(host_mode && host_strobe));

    p_start_order_r4: assert property (@(posedge clk) disable iff (rst)
        flag_start1 |-> flag_start2);

    p_hold_idle_clk_r8: assert property (@(posedge clk) disable iff (rst)
        (in_subq && host_mode && host_strobe && !(host_sclk && !sclk_d))
        |=> $stable(line_out));

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));

endmodule

bind stsub_readout stsub_readout_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_mode   (host_mode),
    .host_strobe (host_strobe),
    .host_sclk   (host_sclk),
    .line_out    (line_out),
    .line_oe     (line_oe),
    .in_subq     (in_subq),
    .flag_start1 (flags_q.start1),
    .flag_start2 (flags_q.start2),
    .bit_cnt     (bit_cnt)
);

// File: tb/stsub_readout_tb.sv
module stsub_readout_tb;

    localparam int SPD_W  = 16;
    localparam int WORD_W = 96;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_mode = 1'b0;
    logic              host_strobe = 1'b0;
    logic              host_sclk = 1'b0;
    logic [2:0]        cfg_stat_sel = 3'd0;
    logic              cfg_stop_fine = 1'b0;
    logic              stat_subq_rdy_n = 1'b1;
    logic              stat_pll_lock = 1'b0;
    logic              pin_v1 = 1'b0;
    logic              pin_v2 = 1'b0;
    logic              stat_motor_sat = 1'b0;
    logic [SPD_W-1:0]  spd_meas = '0;
    logic [SPD_W-1:0]  spd_nominal = '0;
    logic [WORD_W-1:0] subq_word = '0;
    logic              line_out;
    logic              line_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int seed_dummy;

    always #2 clk = ~clk;

    stsub_readout #(.SPD_W(SPD_W), .WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst(rst),
        .host_mode(host_mode), .host_strobe(host_strobe), .host_sclk(host_sclk),
        .cfg_stat_sel(cfg_stat_sel), .cfg_stop_fine(cfg_stop_fine),
        .stat_subq_rdy_n(stat_subq_rdy_n), .stat_pll_lock(stat_pll_lock),
        .pin_v1(pin_v1), .pin_v2(pin_v2), .stat_motor_sat(stat_motor_sat),
        .spd_meas(spd_meas), .spd_nominal(spd_nominal), .subq_word(subq_word),
        .line_out(line_out), .line_oe(line_oe)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    function automatic logic exp_flag(input int sel, input longint spd, input longint nom,
                                      input bit fine, input bit rdy_n, input bit pll,
                                      input bit v1, input bit v2, input bit sat);
        case (sel)
            0: return rdy_n;
            1: return (4 * spd >= 3 * nom);
            2: return (2 * spd >= nom);
            3: return fine ? (100 * spd <= 6 * nom) : (100 * spd <= 12 * nom);
            4: return pll;
            5: return v1;
            6: return v2;
            default: return sat;
        endcase
    endfunction

    function automatic string req_of(input int sel);
        case (sel)
            1, 2:    return "R4";
            3:       return "R5";
            4, 5, 6, 7: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic status_check(input int sel, input int spd, input int nom, input bit fine);
        logic e;
        cfg_stat_sel  = sel[2:0];
        spd_meas      = spd[SPD_W-1:0];
        spd_nominal   = nom[SPD_W-1:0];
        cfg_stop_fine = fine;
        tick();
        e = exp_flag(sel, spd, nom, fine, stat_subq_rdy_n, stat_pll_lock, pin_v1, pin_v2, stat_motor_sat);
        check(line_out, e, req_of(sel), $sformatf("status sel=%0d spd=%0d nom=%0d fine=%0b", sel, spd, nom, fine));
        check(line_oe, 1'b1, "R3", "oe during status");
    endtask

    task automatic open_status();
        host_sclk   = 1'b0;
        host_strobe = 1'b0;
        tick();
        host_mode   = 1'b1;
        host_strobe = 1'b1;
        tick();
    endtask

    task automatic subq_read(input logic [WORD_W-1:0] w, input int len, input bit change_mid);
        cfg_stat_sel = 3'd0;
        subq_word    = w;
        open_status();
        stat_subq_rdy_n = 1'($urandom_range(0, 1));
        tick();
        check(line_out, stat_subq_rdy_n, "R3", "subq-ready before read");
        for (int i = 0; i < len; i++) begin
            host_sclk = 1'b1;
            tick();
            check(line_out, (i < WORD_W) ? w[WORD_W-1-i] : 1'b0,
                  (i == 0) ? "R7" : ((i >= WORD_W) ? "R10" : (change_mid ? "R9" : "R8")),
                  $sformatf("subcode bit %0d", i));
            if (change_mid && i == len / 2) subq_word = ~w;
            host_sclk = 1'b0;
            for (int k = 0; k < int'($urandom_range(1, 3)); k++) tick();
            check(line_out, (i < WORD_W) ? w[WORD_W-1-i] : 1'b0, "R8",
                  $sformatf("hold bit %0d with idle clock", i));
        end
        host_strobe = 1'b0;
        tick();
        check(line_oe, 1'b0, "R10", $sformatf("oe after abort at %0d bits", len));
        check(line_out, 1'b0, "R10", "line low after abort");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] w;
        seed_dummy = $urandom(32'h5eed_0042);

        // R1: reset state
        tick();
        check(line_oe, 1'b0, "R1", "oe in reset");
        check(line_out, 1'b0, "R1", "out in reset");
        host_mode = 1'b1;
        host_strobe = 1'b1;
        tick();
        check(line_oe, 1'b0, "R1", "oe held in reset despite host");
        host_mode = 1'b0;
        host_strobe = 1'b0;
        rst = 1'b0;
        tick();
        check(line_oe, 1'b0, "R1", "oe after reset");
        check(line_out, 1'b0, "R1", "out after reset");

        // R2: enable gating
        host_mode = 1'b0; host_strobe = 1'b1; tick();
        check(line_oe, 1'b0, "R2", "mode low");
        host_mode = 1'b1; host_strobe = 1'b0; tick();
        check(line_oe, 1'b0, "R2", "strobe low");
        host_strobe = 1'b1; tick();
        check(line_oe, 1'b1, "R2", "both high");
        host_mode = 1'b0; tick();
        check(line_oe, 1'b0, "R2", "mode dropped");
        check(line_out, 1'b0, "R2", "line low when off");
        host_mode = 1'b1; tick();

        // R4/R5 boundaries
        status_check(1, 75, 100, 0);
        status_check(1, 74, 100, 0);
        status_check(1, 750, 1000, 0);
        status_check(1, 749, 1000, 0);
        status_check(2, 50, 100, 0);
        status_check(2, 49, 100, 0);
        status_check(2, 500, 999, 0);
        status_check(2, 499, 999, 0);
        status_check(3, 12, 100, 0);
        status_check(3, 13, 100, 0);
        status_check(3, 120, 1000, 0);
        status_check(3, 121, 1000, 0);
        status_check(3, 6, 100, 1);
        status_check(3, 7, 100, 1);
        status_check(3, 12, 100, 1);
        status_check(3, 3932, 65535, 1);
        status_check(3, 3933, 65535, 1);
        status_check(1, 65535, 65535, 0);

        // R3/R6 random status patterns
        for (int it = 0; it < 300; it++) begin
            int nom;
            nom = int'($urandom_range(1, 60000));
            stat_subq_rdy_n = 1'($urandom_range(0, 1));
            stat_pll_lock   = 1'($urandom_range(0, 1));
            pin_v1          = 1'($urandom_range(0, 1));
            pin_v2          = 1'($urandom_range(0, 1));
            stat_motor_sat  = 1'($urandom_range(0, 1));
            status_check(int'($urandom_range(0, 7)),
                         int'($urandom_range(0, (nom * 5) / 4 > 65535 ? 65535 : (nom * 5) / 4)),
                         nom, 1'($urandom_range(0, 1)));
        end

        // R11: sclk rise with non-subcode selector
        cfg_stat_sel = 3'd4;
        stat_pll_lock = 1'b1;
        tick();
        host_sclk = 1'b1; tick();
        check(line_out, 1'b1, "R11", "pll after sclk rise");
        host_sclk = 1'b0;
        stat_pll_lock = 1'b0;
        tick();
        check(line_out, 1'b0, "R11", "still status mode");
        cfg_stat_sel = 3'd5;
        pin_v1 = 1'b1;
        tick();
        check(line_out, 1'b1, "R11", "v1 after sclk rise");

        // R7/R8/R9/R10 directed subcode reads
        w = {32'hA5C3_0F1E, 32'h8000_0001, 32'h7FFF_FFFE};
        subq_read(w, 1, 0);
        subq_read(w, 96, 1);
        subq_read(w, 98, 0);
        w = ~w;
        subq_read(w, 5, 0);
        subq_read(w, 3, 1);

        // random reads
        for (int it = 0; it < 25; it++) begin
            w = {$urandom, $urandom, $urandom};
            subq_read(w, int'($urandom_range(1, 96)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule